// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Port

This block holds the configuration of a frequency synthesizer. It keeps three registers: a 9-bit feedback divider value M, a 2-bit output divider value N and a 2-bit test selector T. M and N can be written in two ways. A parallel port carries a strobe that is active low. A three-wire serial port carries data, a serial clock and a load line. Control passes from one port to the other. Whichever port wrote the registers last owns them until the other port acts. The block also drives a test pin, which is chosen by T. It flags whether the current M lies in the range where the loop can lock.

Every input pin is asynchronous to the system clock. Each one passes through a two-stage synchronizer. The serial clock and the load line are then edge-detected, so all state changes happen on the system clock. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level, and the outputs are register values that hold until the next load. After master reset the block acts as if the parallel strobe were low. Hardwired parallel values therefore appear on the outputs shortly after power-up.

Top module: `synth_divcfg`

## Requirements
- R1: While `rst_n` is low, `t_val` is 00, `test_out` is low, `m_val`/`n_val` are zero and the serial shift register is cleared. After release the block is in parallel mode until the strobe pin is seen high.
- R2: While the synchronized parallel strobe `par_ld_n` is low, `m_val`/`n_val` follow `par_m`/`par_n`. This overrides any value loaded earlier through the serial port. `t_val` is not changed by the parallel port.
- R3: Once the strobe has risen, `m_val`, `n_val` and `t_val` hold. They change only when the strobe goes low again or a serial load event happens (a rising `ser_ld`, or a serial clock rise while `ser_ld` is high).
- R4: With the strobe high, each rising `ser_clk` shifts `ser_dat` into a 14-bit shift register. Serial clock rises while the strobe is low are ignored. Shifting alone, with `ser_ld` low, does not change the outputs.
- R5: On a rising `ser_ld` (strobe high), the shift register is copied to the outputs. The first bit sent ends in bit 13. The frame, first bit first, is T1, T0, a null bit, N1, N0, M8 down to M0. So T = bits 13:12, N = bits 10:9 and M = bits 8:0. The null bit (bit 11) has no effect.
- R6: While `ser_ld` stays high, each serial clock rise copies the newly shifted register to the outputs. After `ser_ld` falls, the outputs are frozen.
- R7: In serial mode `test_out` is set by `t_val`: 00 gives low, 01 gives the synchronized `ser_dat`, 10 gives `mdiv_clk`, and 11 gives `fout_clk`.
- R8: While the synchronized strobe is low, `test_out` is low for every value of `t_val`.
- R9: `m_ok` is high exactly when 8 <= `m_val` <= 28.
- R10: A pin level first sampled at clock edge e reaches `m_val`/`n_val`/`t_val` after edge e+2. It reaches the mode and data view used by `test_out` after edge e+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| par_ld_n | input | 1 | Parallel strobe: low = transparent, rise = capture |
| par_m | input | 9 | Parallel feedback divider value |
| par_n | input | 2 | Parallel output divider value |
| ser_clk | input | 1 | Serial shift clock (sampled) |
| ser_dat | input | 1 | Serial data bit |
| ser_ld | input | 1 | Serial load line |
| mdiv_clk | input | 1 | Feedback divider output, for the test pin |
| fout_clk | input | 1 | Main output clock, for the test pin |
| m_val | output | 9 | Current feedback divider value |
| n_val | output | 2 | Current output divider value |
| t_val | output | 2 | Current test selector |
| m_ok | output | 1 | M lies inside the lock range |
| test_out | output | 1 | Test pin selected by t_val |

## Verification
On every cycle, the assertions check the parallel pass-through with its fixed three-edge latency, and that the registers hold when neither port acts. They also check that the test pin is low in parallel mode, that each test selection routes the right source, and that the range flag agrees with M. The ownership hand-over can only be shown by the bench's scenarios, driven against its behavioural model. These scenarios cover a serial load that overrides a parallel value, and a parallel strobe that overrides a serial value. They also show that the null slot has no effect, that shifting done in parallel mode is ignored, and that M/N/T freeze after the load line falls.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  parameter int M_W    = 9;
  parameter int N_W    = 2;
  parameter int T_W    = 2;
  parameter int NULL_W = 1;

  localparam int FRAME_W = T_W + NULL_W + N_W + M_W;
  localparam int M_LSB   = 0;
  localparam int N_LSB   = M_W;
  localparam int T_LSB   = M_W + N_W + NULL_W;

  typedef enum logic [T_W-1:0] {
    TSEL_LOW  = 2'd0,
    TSEL_SDAT = 2'd1,
    TSEL_MDIV = 2'd2,
    TSEL_FOUT = 2'd3
  } tsel_e;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/divcfg_frame.sv
module divcfg_frame #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/divcfg_testmux.sv
module divcfg_testmux
  import divcfg_pkg::*;
(
  input  logic           par_mode,
  input  logic [T_W-1:0] sel,
  input  logic           sdat,
  input  logic           mdiv,
  input  logic           fout,
  output logic           y
);
  always_comb begin
    y = 1'b0;
    if (!par_mode) begin
      unique case (tsel_e'(sel))
        TSEL_LOW:  y = 1'b0;
        TSEL_SDAT: y = sdat;
        TSEL_MDIV: y = mdiv;
        TSEL_FOUT: y = fout;
      endcase
    end
  end
endmodule

// File: rtl/synth_divcfg.sv
module synth_divcfg
  import divcfg_pkg::*;
#(
  parameter int M_MIN       = 8,
  parameter int M_MAX       = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_ld_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_ld,
  input  logic           mdiv_clk,
  input  logic           fout_clk,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_val,
  output logic [T_W-1:0] t_val,
  output logic           m_ok,
  output logic           test_out
);
  localparam int PIN_W = 4 + N_W + M_W;

  // synchronized pin view
  logic [PIN_W-1:0] pin_s;
  logic             s_pl, s_sc, s_sd, s_sl;
  logic [N_W-1:0]   s_pn;
  logic [M_W-1:0]   s_pm;

  divcfg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({par_ld_n, ser_clk, ser_dat, ser_ld, par_n, par_m}),
    .q     (pin_s)
  );

  assign {s_pl, s_sc, s_sd, s_sl, s_pn, s_pm} = pin_s;

  // edge detection on serial clock and load line
  logic sc_q, sl_q;
  logic sc_rise, ld_rise, shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q <= 1'b0;
      sl_q <= 1'b0;
    end else begin
      sc_q <= s_sc;
      sl_q <= s_sl;
    end
  end

  assign sc_rise  = s_sc & ~sc_q;
  assign ld_rise  = s_sl & ~sl_q;
  assign shift_en = s_pl & sc_rise;

  // serial frame register, first bit ends at the MSB
  logic [FRAME_W-1:0] sh_q, sh_d;

  assign sh_d = {sh_q[FRAME_W-2:0], s_sd};

  divcfg_frame #(.W(FRAME_W)) u_frame (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (shift_en),
    .d     (sh_d),
    .q     (sh_q)
  );

  // frame field views; the null slot is never read out
  cfg_t cfg_held, cfg_thru;

  assign cfg_held.t = sh_q[T_LSB +: T_W];
  assign cfg_held.n = sh_q[N_LSB +: N_W];
  assign cfg_held.m = sh_q[M_LSB +: M_W];
  assign cfg_thru.t = sh_d[T_LSB +: T_W];
  assign cfg_thru.n = sh_d[N_LSB +: N_W];
  assign cfg_thru.m = sh_d[M_LSB +: M_W];

  // shared divider registers; the parallel port wins while its strobe is low
  cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (!s_pl) begin
      cfg_q.m <= s_pm;
      cfg_q.n <= s_pn;
    end else if (ld_rise) begin
      cfg_q <= cfg_held;
    end else if (s_sl && sc_rise) begin
      cfg_q <= cfg_thru;
    end
  end

  assign m_val = cfg_q.m;
  assign n_val = cfg_q.n;
  assign t_val = cfg_q.t;
  assign m_ok  = (cfg_q.m >= M_W'(M_MIN)) && (cfg_q.m <= M_W'(M_MAX));

  divcfg_testmux u_tmux (
    .par_mode (~s_pl),
    .sel      (cfg_q.t),
    .sdat     (s_sd),
    .mdiv     (mdiv_clk),
    .fout     (fout_clk),
    .y        (test_out)
  );
endmodule

// File: rtl/synth_divcfg_chk.sv
module synth_divcfg_chk
  import divcfg_pkg::*;
#(
  parameter int M_MIN = 8,
  parameter int M_MAX = 28
) (
  input logic           clk,
  input logic           rst_n,
  input logic           par_ld_n,
  input logic [M_W-1:0] par_m,
  input logic [N_W-1:0] par_n,
  input logic           ser_dat,
  input logic           ser_ld,
  input logic           mdiv_clk,
  input logic           fout_clk,
  input logic [M_W-1:0] m_val,
  input logic [N_W-1:0] n_val,
  input logic [T_W-1:0] t_val,
  input logic           m_ok,
  input logic           test_out
);
  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 7) since_rst <= since_rst + 3'd1;
  end

  // R2, R10: parallel pass-through lands three edges after sampling
  a_r2_par_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4 && !$past(par_ld_n, 3)) |->
      (m_val == $past(par_m, 3) && n_val == $past(par_n, 3)));

  // R3: no parallel transparency and no serial load activity -> hold
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4 && $past(par_ld_n, 3) && !$past(ser_ld, 3)) |->
      ($stable(m_val) && $stable(n_val) && $stable(t_val)));

  // R8: test pin low in parallel mode
  a_r8_par_test_low: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4 && !$past(par_ld_n, 2)) |-> !test_out);

  // R7: test pin selections
  a_r7_sel_low: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4 && t_val == 2'b00) |-> !test_out);

  a_r7_sel_sdat: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4 && $past(par_ld_n, 2) && t_val == 2'b01) |->
      (test_out == $past(ser_dat, 2)));

  a_r7_sel_mdiv: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4 && $past(par_ld_n, 2) && t_val == 2'b10) |->
      (test_out == mdiv_clk));

  a_r7_sel_fout: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4 && $past(par_ld_n, 2) && t_val == 2'b11) |->
      (test_out == fout_clk));

  // R9: range flag against M
  a_r9_flag_in: assert property (@(posedge clk) disable iff (!rst_n)
    m_ok |-> (m_val >= M_W'(M_MIN) && m_val <= M_W'(M_MAX)));

  a_r9_flag_out: assert property (@(posedge clk) disable iff (!rst_n)
    (m_val < M_W'(M_MIN) || m_val > M_W'(M_MAX)) |-> !m_ok);
endmodule

bind synth_divcfg synth_divcfg_chk #(.M_MIN(M_MIN), .M_MAX(M_MAX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .par_ld_n (par_ld_n),
  .par_m    (par_m),
  .par_n    (par_n),
  .ser_dat  (ser_dat),
  .ser_ld   (ser_ld),
  .mdiv_clk (mdiv_clk),
  .fout_clk (fout_clk),
  .m_val    (m_val),
  .n_val    (n_val),
  .t_val    (t_val),
  .m_ok     (m_ok),
  .test_out (test_out)
);

// File: tb/test_synth_divcfg.sv
module test_synth_divcfg;
  import divcfg_pkg::*;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       par_ld_n = 1'b0;
  logic [8:0] par_m = 9'd20;
  logic [1:0] par_n = 2'd1;
  logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
  logic       mdiv_clk = 1'b0, fout_clk = 1'b0;
  logic [8:0] m_val;
  logic [1:0] n_val, t_val;
  logic       m_ok, test_out;

  int nchk = 0, nbad = 0;
  bit ended = 0;

  always #(PERIOD/2) clk = ~clk;

  synth_divcfg i_synth_divcfg (
    .clk(clk), .rst_n(rst_n), .par_ld_n(par_ld_n), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
    .mdiv_clk(mdiv_clk), .fout_clk(fout_clk),
    .m_val(m_val), .n_val(n_val), .t_val(t_val), .m_ok(m_ok), .test_out(test_out)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct packed {
    logic pl, sc, sd, sl;
    logic [8:0] pm;
    logic [1:0] pn;
  } pins_t;

  pins_t       hist[$];
  pins_t       cur, old;
  logic [8:0]  em;
  logic [1:0]  en, et;
  logic [13:0] esh, nsh;
  logic        ep_pl, ep_sd;

  task automatic take(input logic [13:0] f);
    et = f[13:12];
    en = f[10:9];
    em = f[8:0];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {};
      repeat (3) hist.push_front('0);
      em = '0; en = '0; et = '0; esh = '0; ep_pl = 1'b0; ep_sd = 1'b0;
    end else begin
      hist.push_front({par_ld_n, ser_clk, ser_dat, ser_ld, par_m, par_n});
      cur = hist[2];
      old = hist[3];
      nsh = {esh[12:0], cur.sd};
      if (!cur.pl) begin
        em = cur.pm;
        en = cur.pn;
      end else begin
        if (cur.sl && !old.sl)                 take(esh);
        else if (cur.sl && cur.sc && !old.sc)  take(nsh);
        if (cur.sc && !old.sc) esh = nsh;
      end
      void'(hist.pop_back());
      ep_pl = hist[1].pl;
      ep_sd = hist[1].sd;
    end
  end

  function automatic logic exp_test();
    if (!ep_pl) return 1'b0;
    case (et)
      2'b00:   return 1'b0;
      2'b01:   return ep_sd;
      2'b10:   return mdiv_clk;
      default: return fout_clk;
    endcase
  endfunction

  // per-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(PERIOD/4);
    if (rst_n && !ended) begin
      cmp("R2 R4 R5 R6 m_val per-cycle", m_val, em);
      cmp("R2 R5 R6 n_val per-cycle", n_val, en);
      cmp("R5 R6 t_val per-cycle", t_val, et);
      cmp("R9 m_ok per-cycle", m_ok, (em >= 8 && em <= 28));
      cmp("R7 R8 test_out per-cycle", test_out, exp_test());
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    @(negedge clk); ser_dat = b;
    idle(3); ser_clk = 1'b1;
    idle(3); ser_clk = 1'b0;
  endtask

  task automatic send(input logic [1:0] t, input logic nul, input logic [1:0] n,
                      input logic [8:0] m, input bit pulse);
    logic [13:0] f;
    f = {t, nul, n, m};
    for (int i = 13; i >= 0; i--) sbit(f[i]);
    if (pulse) begin
      idle(2); ser_ld = 1'b1;
      idle(6); ser_ld = 1'b0;
      idle(6);
    end
  endtask

  task automatic check_cfg(input string tag, input logic [1:0] t, input logic [1:0] n,
                           input logic [8:0] m);
    cmp({tag, " m"}, m_val, m);
    cmp({tag, " n"}, n_val, n);
    cmp({tag, " t"}, t_val, t);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(PERIOD * 100000);
    nchk++; nbad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  // ---------------- directed scenarios ----------------
  initial begin
    logic [13:0] fx, fexp;
    idle(3);
    cmp("R1 reset t_val", t_val, 0);
    cmp("R1 reset test_out", test_out, 0);
    cmp("R1 reset m_val", m_val, 0);
    rst_n = 1'b1;
    idle(6);
    cmp("R1 hardwired parallel value after reset", m_val, 20);
    cmp("R2 n follows parallel", n_val, 1);
    cmp("R9 m=20 in range", m_ok, 1);

    // R9 range edges
    par_m = 9'd7;  idle(5); cmp("R9 m=7 out of range", m_ok, 0);
    par_m = 9'd8;  idle(5); cmp("R9 m=8 in range", m_ok, 1);
    par_m = 9'd28; idle(5); cmp("R9 m=28 in range", m_ok, 1);
    par_m = 9'd29; idle(5); cmp("R9 m=29 out of range", m_ok, 0);

    // R10 latency: drive at a falling edge, observe after 2 and 3 rising edges
    par_m = 9'd100;
    idle(2); cmp("R10 not yet after two edges", m_val, 29);
    idle(1); cmp("R10 visible after three edges", m_val, 100);

    // R3 capture on strobe rise
    par_m = 9'd12; par_n = 2'd3; idle(5);
    par_ld_n = 1'b1; idle(1);
    par_m = 9'd25; par_n = 2'd0; idle(8);
    check_cfg("R3 held after strobe rise", 2'd0, 2'd3, 9'd12);

    // R4 shifting alone leaves outputs alone (mid-frame)
    for (int i = 0; i < 7; i++) sbit(1'b1);
    idle(4);
    check_cfg("R4 shift without load", 2'd0, 2'd3, 9'd12);
    for (int i = 0; i < 7; i++) sbit(1'b0);

    // R5 serial load overrides parallel value
    send(2'b01, 1'b1, 2'd2, 9'd17, 1);
    check_cfg("R5 serial load", 2'd1, 2'd2, 9'd17);
    ser_dat = 1'b1; idle(4); cmp("R7 sel 01 follows data high", test_out, 1);
    ser_dat = 1'b0; idle(4); cmp("R7 sel 01 follows data low", test_out, 0);

    // R5 null slot ignored: same content with both null values
    send(2'b10, 1'b0, 2'd3, 9'd200, 1);
    check_cfg("R5 null=0 frame", 2'd2, 2'd3, 9'd200);
    cmp("R9 m=200 out of range", m_ok, 0);
    mdiv_clk = 1'b1; idle(1); cmp("R7 sel 10 mdiv high", test_out, 1);
    mdiv_clk = 1'b0; idle(1); cmp("R7 sel 10 mdiv low", test_out, 0);
    send(2'b10, 1'b1, 2'd3, 9'd200, 1);
    check_cfg("R5 null=1 frame", 2'd2, 2'd3, 9'd200);

    send(2'b00, 1'b1, 2'd1, 9'd28, 1);
    ser_dat = 1'b1; idle(4);
    cmp("R7 sel 00 stays low", test_out, 0);
    ser_dat = 1'b0;

    // R6 load held high: pass-through, then freeze on fall
    ser_ld = 1'b1; idle(6);
    send(2'b11, 1'b0, 2'd0, 9'd8, 0);
    idle(4);
    check_cfg("R6 pass-through while load high", 2'd3, 2'd0, 9'd8);
    ser_ld = 1'b0; idle(6);
    sbit(1'b0); sbit(1'b1); sbit(1'b0); sbit(1'b1); sbit(1'b1);
    idle(4);
    check_cfg("R6 frozen after load fall", 2'd3, 2'd0, 9'd8);
    fout_clk = 1'b1; idle(1); cmp("R7 sel 11 fout high", test_out, 1);
    fout_clk = 1'b0; idle(1); cmp("R7 sel 11 fout low", test_out, 0);

    // R2 parallel strobe low overrides serial values; R8 test pin low
    par_m = 9'd9; par_n = 2'd2; par_ld_n = 1'b0; fout_clk = 1'b1;
    idle(6);
    check_cfg("R2 parallel overrides serial", 2'd3, 2'd2, 9'd9);
    cmp("R8 test low in parallel mode", test_out, 0);

    // R4 serial clock ignored in parallel mode
    sbit(1'b1); sbit(1'b1); sbit(1'b1);
    par_ld_n = 1'b1; idle(6);
    ser_ld = 1'b1; idle(6); ser_ld = 1'b0; idle(6);
    fx   = {2'b11, 1'b0, 2'd0, 9'd8};
    fexp = {fx[8:0], 5'b01011};
    check_cfg("R4 parallel-mode clocks ignored", fexp[13:12], fexp[10:9], fexp[8:0]);
    fout_clk = 1'b0;

    idle(4);
    finish_run();
  end
endmodule